// File: doc/BRIEF.md
# Glitch-Free Clock Output Freeze Controller

This block sits between a bank of clock dividers and the clock output pins. It receives twelve divided clocks that all run from one fast clock. Each of them passes through a gate that can hold that output low. A freeze mask chooses which outputs are held low. The mask is loaded one bit per fast-clock cycle through a serial port and becomes active when a load strobe is pulsed.

The dividers upstream are never stopped. While an output is frozen, its source clock keeps toggling behind the gate. When the freeze is lifted, the output resumes in step with every output that stayed enabled. A gate opens or closes only on a fast-clock edge at which its source clock was sampled low. As a result, no output ever produces a shortened high pulse.

Top module: `clk_freeze_ctrl`

## Requirements
- R1: After reset, every output is enabled: each gated clock equals its source clock, and both the staged word and the active mask are zero.
- R2: On every fast-clock edge the serial port shifts `ser_din` into a 12-bit staging register, most significant bit first. The first of twelve shifted bits ends in bit 11 and the last in bit 0. Bit i controls output i. A `ser_load` sampled high copies the staged word, as it stood before that edge, into the active mask.
- R3: Shifting with `ser_load` low leaves the active mask unchanged, and so leaves every output's gating unchanged.
- R4: An output whose active mask bit is 1 is held low. This starts at the first edge at which its source clock is sampled low.
- R5: A change of a mask bit takes effect only at an edge where that output's source clock was sampled low. While the source stays high, the output keeps its previous gating.
- R6: An output whose mask bit is 0 follows its source clock exactly, including after it is unfrozen, so it stays in phase with the other enabled outputs.
- R7: A gated output rises only when its source clock rises and falls only when its source clock falls, so no runt pulse is produced.
- R8: The twelve outputs are gated independently; a mask bit affects only its own output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock that drives the dividers and this block |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_clk | input | 12 | Ungated divided clocks, synchronous to clk |
| ser_din | input | 1 | Serial mask data, MSB first |
| ser_load | input | 1 | Strobe that moves the staged word into the active mask |
| gclk | output | 12 | Gated clock outputs |

## Verification
On every cycle, the assertions check three things. Each gated output switches only together with the matching edge of its source. A frozen output is low once its source has been sampled low. An enabled output tracks its source. They also check that the active mask does not move without a load strobe.

The bench scenarios cover the rest:
- that the serial bit order lands on the intended outputs;
- that a freeze requested while a source is high waits for the low phase;
- that unfrozen outputs come back in phase;
- that random masks over random divider ratios gate each output independently.

// File: rtl/cfo_pkg.sv
package cfo_pkg;
    // Number of gated clock outputs in the default configuration.
    localparam int unsigned OUT_COUNT = 12;
    // Smallest legal staging register width (shift needs two bits).
    localparam int unsigned MIN_WIDTH = 2;
endpackage

// File: rtl/cfo_mask_loader.sv
module cfo_mask_loader #(
    parameter int unsigned W = cfo_pkg::OUT_COUNT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_din,
    input  logic         ser_load,
    output logic [W-1:0] mask_o
);
    typedef struct packed {
        logic [W-1:0] stage;
        logic [W-1:0] mask;
    } ld_state_t;

    ld_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        // R2: MSB-first shift, newest bit enters at bit 0
        st_d.stage = {st_q.stage[W-2:0], ser_din};
        if (ser_load) begin
            st_d.mask = st_q.stage;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.mask;

    // R3
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_load |=> $stable(mask_o));

    initial begin
        width_ok_chk: assert (W >= cfo_pkg::MIN_WIDTH);
    end
endmodule

// File: rtl/cfo_gate_cell.sv
module cfo_gate_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic src_clk,
    input  logic freeze,
    output logic gclk_o
);
    typedef struct packed {
        logic en;
    } gate_state_t;

    gate_state_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        // R5: enable follows the mask only during the source low phase
        if (!src_clk) begin
            g_d.en = ~freeze;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q.en <= 1'b1;
        end else begin
            g_q <= g_d;
        end
    end

    assign gclk_o = src_clk & g_q.en;

    // R7
    rise_with_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gclk_o) |-> $rose(src_clk));

    // R7
    fall_with_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gclk_o) |-> $fell(src_clk));

    // R4
    frozen_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(freeze) && !$past(src_clk)) |-> !gclk_o);

    // R6
    enabled_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(freeze) && !$past(src_clk)) |-> (gclk_o == src_clk));
endmodule

// File: rtl/clk_freeze_ctrl.sv
module clk_freeze_ctrl #(
    parameter int unsigned NUM_OUT = cfo_pkg::OUT_COUNT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OUT-1:0] src_clk,
    input  logic               ser_din,
    input  logic               ser_load,
    output logic [NUM_OUT-1:0] gclk
);
    logic [NUM_OUT-1:0] active_mask;

    cfo_mask_loader #(.W(NUM_OUT)) u_loader (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_din  (ser_din),
        .ser_load (ser_load),
        .mask_o   (active_mask)
    );

    // R8: one independent gate per output
    for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_gate
        cfo_gate_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_clk (src_clk[gi]),
            .freeze  (active_mask[gi]),
            .gclk_o  (gclk[gi])
        );
    end
endmodule

// File: tb/tb_clk_freeze_ctrl.sv
module tb_clk_freeze_ctrl;
    localparam int  N          = 12;
    localparam time CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic         ser_din = 1'b0;
    logic         ser_load = 1'b0;
    logic [N-1:0] gclk;

    int vectors = 0;
    int misses  = 0;
    logic [N-1:0] m_stage = '0, m_mask = '0, m_en = '1;
    logic [N-1:0] prev_src = '0, prev_g = '0;
    int hp [N];
    int cnt [N];
    string cur_req = "R1";
    bit done = 0;

    clk_freeze_ctrl #(.NUM_OUT(N)) dut (
        .clk(clk), .rst_n(rst_n), .src_clk(src),
        .ser_din(ser_din), .ser_load(ser_load), .gclk(gclk)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [N-1:0] exp_out(input logic [N-1:0] s, input logic [N-1:0] e);
        return s & e;
    endfunction

    task automatic report(input string tag, input logic [N-1:0] act, input logic [N-1:0] expv);
        misses++;
        $display("FAIL %s: gclk actual=%h expected=%h at %0t", tag, act, expv, $time);
    endtask

    // model effect of the edge that just passed, using inputs still applied
    task automatic model_step();
        logic [N-1:0] ns, nm, ne;
        if (!rst_n) begin
            m_stage = '0; m_mask = '0; m_en = '1;
        end else begin
            ns = {m_stage[N-2:0], ser_din};
            nm = ser_load ? m_stage : m_mask;
            ne = m_en;
            for (int i = 0; i < N; i++) if (!src[i]) ne[i] = ~m_mask[i];
            m_stage = ns; m_mask = nm; m_en = ne;
        end
    endtask

    task automatic tick(input logic din, input logic ld);
        logic [N-1:0] expv;
        bit bad;
        @(negedge clk);
        model_step();
        vectors++;
        bad = 0;
        expv = exp_out(src, m_en);
        if (gclk !== expv) begin
            report(cur_req, gclk, expv); bad = 1;
        end
        for (int i = 0; i < N; i++) begin
            if (!bad && rst_n && (gclk[i] != prev_g[i]) && (src[i] == prev_src[i])) begin
                report("R7", gclk, expv); bad = 1;
            end
        end
        prev_g = gclk; prev_src = src;
        ser_din = din; ser_load = ld;
        for (int i = 0; i < N; i++) begin
            cnt[i]++;
            if (cnt[i] >= hp[i]) begin cnt[i] = 0; src[i] = ~src[i]; end
        end
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) tick(1'($urandom % 2), 1'b0);
    endtask

    task automatic load_word(input logic [N-1:0] w);
        for (int k = N - 1; k >= 0; k--) tick(w[k], 1'b0);
        tick(1'($urandom % 2), 1'b1);
    endtask

    task automatic direct_check(input string tag, input logic [N-1:0] expv);
        @(negedge clk);
        vectors++;
        if (gclk !== expv) report(tag, gclk, expv);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        vectors++; misses++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) begin hp[i] = 1 + (i % 4); cnt[i] = 0; end
        // R1: reset state, then all outputs enabled
        cur_req = "R1";
        run(4);
        @(negedge clk); rst_n = 1'b1;
        run(10);
        // R3: shift random data with no load, gating must stay fully open
        cur_req = "R3";
        run(40);
        direct_check("R3", src);
        // R2: bit order, MSB first lands on output 11, last bit on output 0
        cur_req = "R2";
        load_word(12'b1000_0000_0001);
        run(12);
        direct_check("R2", src & 12'h7FE);
        // R4: freeze everything, outputs held low
        cur_req = "R4";
        load_word('1);
        run(12);
        for (int k = 0; k < 8; k++) direct_check("R4", '0);
        // R6: unfreeze, outputs follow sources in phase
        cur_req = "R6";
        load_word('0);
        run(12);
        direct_check("R6", src);
        // R5: slow source on output 3, freeze requested at varied phases
        cur_req = "R5";
        hp[3] = 7;
        for (int r = 0; r < 6; r++) begin
            load_word(12'h008);
            run(3 + r);
            load_word(12'h000);
            run(2 + r);
        end
        // R8: random masks over random divider ratios
        cur_req = "R8";
        for (int r = 0; r < 40; r++) begin
            for (int i = 0; i < N; i++) hp[i] = 1 + ($urandom % 5);
            load_word(N'($urandom));
            run(8 + ($urandom % 30));
        end
        finish_run();
    end
endmodule